// File: doc/BRIEF.md
# ATM Cell Next-Hop VCI Rewriter

This block sits in the cell stream of an ATM line card. It accepts 14-word cells, each made of 32-bit words, on a streaming input. The first word of each cell is flagged by a start strobe, and a flow-control flag from the block tells the upstream source when a new cell may begin. Every cell goes into one local cell buffer, in arrival order. When a cell's header carries the virtual circuit that is currently set as the IP circuit, and that cell opens a packet, the block takes the IPv4 destination address from word index 6 and pushes it into an external lookup request queue.

On the output side, cells are sent whole and in the order they arrived. A cell that opens an IP packet is held at the head of the buffer until the external result queue has a next hop ready. The block then pops that result and writes it into the VCI field of the header. The same next hop is reused for the later cells of that packet. Cells on any other circuit leave exactly as they came in.

Top module: `atm_ip_vci_rewriter`

## Requirements
- R1: A cell whose header VCI (bits [19:4]) differs from `ip_vci` leaves with all 14 words unchanged.
- R2: For the first cell of each IP packet, word index 6 (the header is index 0) is pushed once on `req_push`/`req_addr`, and never while `req_full` is high.
- R3: The header of the first cell of an IP packet leaves with bits [19:4] replaced by the popped next hop, while bits [31:20], bits [3:0] and all payload words stay unchanged.
- R4: A packet ends with the cell whose header bit 1 is set. Later IP cells of the same packet carry the same next hop in bits [19:4], and they cause no request and no pop.
- R5: A cell that opens an IP packet does not start while `rsp_empty` is high. `rsp_pop` pulses for exactly one cycle per packet, in the cycle the cell starts, so results are used in request order.
- R6: Cells leave in arrival order. `out_soc` marks word 0, and the other 13 words follow on consecutive cycles.
- R7: No cell starts on the output unless `out_tca` was high in the cycle before `out_soc`.
- R8: `in_tca` is low whenever the cell buffer has fewer than 14 free words, whenever `req_full` is high, or while an input cell is still arriving.
- R9: After reset, `out_soc`, `out_data`, `req_push` and `rsp_pop` are zero and `in_tca` is high.
- R10: The IP circuit is taken from `ip_vci` (for example 0x003E or 0x0064). Once it changes, cells on the old value pass unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ip_vci | input | 16 | VCI that marks IP traffic |
| in_soc | input | 1 | First word of an incoming cell |
| in_data | input | 32 | Incoming cell word |
| in_tca | output | 1 | A new cell may start on the input |
| out_soc | output | 1 | First word of an outgoing cell |
| out_data | output | 32 | Outgoing cell word |
| out_tca | input | 1 | Downstream can take a new cell |
| req_push | output | 1 | Push a destination address into the lookup request queue |
| req_addr | output | 32 | Destination address being pushed |
| req_full | input | 1 | Lookup request queue cannot take an entry |
| rsp_empty | input | 1 | Result queue holds no next hop |
| rsp_hop | input | 16 | Next hop at the head of the result queue |
| rsp_pop | output | 1 | Consume the head of the result queue |

## Verification
The assertions assume the following about the inputs. The upstream source begins a cell only in a cycle where `in_tca` is high, and it then sends all 14 words back to back. `req_full` rises only as a result of the block's own pushes. The head of the result queue stays stable until it is popped. `ip_vci` changes only while no cell is in flight. The bench keeps to these rules as follows: it reads `in_tca` before it drives a start strobe, and it streams every cell without gaps. Its result queue model only ever grows at the tail and only moves its head on a pop. It reconfigures `ip_vci` only after every queued cell has drained.

// File: rtl/atm_rw_pkg.sv
package atm_rw_pkg;
  // One buffered word with the tags the output side needs
  typedef struct packed {
    logic        soc;      // word 0 of a cell
    logic        need;     // opening cell of an IP packet: pop a result
    logic        use_hop;  // any IP cell: rewrite its header
    logic [31:0] data;
  } cw_t;
endpackage

// File: rtl/atm_rw_cellbuf.sv
module atm_rw_cellbuf
  import atm_rw_pkg::*;
#(
  parameter int DEPTH = 56,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  cw_t              wr_word,
  input  logic             rd_en,
  output cw_t              rd_word,
  output logic [LVL_W-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  cw_t              mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    if (wr_en) wp_d = (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
    if (rd_en) rp_d = (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
    case ({wr_en, rd_en})
      2'b10:   lvl_d = lvl_q + 1'b1;
      2'b01:   lvl_d = lvl_q - 1'b1;
      default: lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_word;
  end

  assign rd_word = mem[rp_q];
  assign level   = lvl_q;
endmodule

// File: rtl/atm_rw_ingress.sv
module atm_rw_ingress
  import atm_rw_pkg::*;
#(
  parameter int CELL_WORDS  = 14,
  parameter int ADDR_WORD   = 6,
  parameter int DEPTH_WORDS = 56,
  parameter int LVL_W       = 6,
  parameter int VCI_LSB     = 4,
  parameter int VCI_W       = 16,
  parameter int LAST_BIT    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VCI_W-1:0] ip_vci,
  input  logic             in_soc,
  input  logic [31:0]      in_data,
  output logic             in_tca,
  input  logic             req_full,
  output logic             req_push,
  output logic [31:0]      req_addr,
  input  logic [LVL_W-1:0] level,
  output logic             wr_en,
  output cw_t              wr_word
);
  localparam int IDX_W = $clog2(CELL_WORDS);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(CELL_WORDS - 1);
  localparam logic [IDX_W-1:0] IDX_ADDR = IDX_W'(ADDR_WORD);
  localparam logic [LVL_W-1:0] ROOM_MAX = LVL_W'(DEPTH_WORDS - CELL_WORDS);

  logic             busy_q, busy_d, need_q, need_d, pkt_q, pkt_d, run_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             start, hdr_ip, opens;

  assign start  = in_soc && !busy_q;
  assign hdr_ip = (in_data[VCI_LSB +: VCI_W] == ip_vci);
  assign opens  = hdr_ip && !pkt_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    need_d = need_q;
    pkt_d  = pkt_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = IDX_W'(1);
      need_d = opens;
      if (hdr_ip) pkt_d = !in_data[LAST_BIT];
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == IDX_END) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      need_q <= 1'b0;
      pkt_q  <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      need_q <= need_d;
      pkt_q  <= pkt_d;
      run_q  <= 1'b1;
    end
  end

  assign wr_en   = start || busy_q;
  assign wr_word = '{soc: start, need: start && opens,
                     use_hop: start && hdr_ip, data: in_data};

  assign req_push = busy_q && need_q && (idx_q == IDX_ADDR);
  assign req_addr = in_data;

  assign in_tca = run_q && !busy_q && !req_full && (level <= ROOM_MAX);
endmodule

// File: rtl/atm_rw_egress.sv
module atm_rw_egress
  import atm_rw_pkg::*;
#(
  parameter int CELL_WORDS = 14,
  parameter int LVL_W      = 6,
  parameter int VCI_LSB    = 4,
  parameter int HOP_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  cw_t              head,
  output logic             rd_en,
  input  logic             out_tca,
  input  logic             rsp_empty,
  input  logic [HOP_W-1:0] rsp_hop,
  output logic             rsp_pop,
  output logic             out_soc,
  output logic [31:0]      out_data
);
  localparam int IDX_W = $clog2(CELL_WORDS);
  localparam logic [IDX_W-1:0] IDX_END   = IDX_W'(CELL_WORDS - 1);
  localparam logic [LVL_W-1:0] CELL_LVL  = LVL_W'(CELL_WORDS);

  logic             busy_q, busy_d, soc_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [HOP_W-1:0] hop_q, hop_sel;
  logic [31:0]      word_d, data_q;
  logic             start;

  // A cell starts only when it is fully buffered, so its words stream without gaps
  assign start = !busy_q && head.soc && (level >= CELL_LVL) && out_tca &&
                 (!head.need || !rsp_empty);
  assign rd_en   = start || busy_q;
  assign rsp_pop = start && head.need;
  assign hop_sel = head.need ? rsp_hop : hop_q;

  always_comb begin
    word_d = head.data;
    if (start && head.use_hop) word_d[VCI_LSB +: HOP_W] = hop_sel;
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = IDX_W'(1);
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == IDX_END) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      hop_q  <= '0;
      soc_q  <= 1'b0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      if (rsp_pop) hop_q <= rsp_hop;
      soc_q  <= start;
      data_q <= rd_en ? word_d : '0;
    end
  end

  assign out_soc  = soc_q;
  assign out_data = data_q;
endmodule

// File: rtl/atm_ip_vci_rewriter.sv
module atm_ip_vci_rewriter
  import atm_rw_pkg::*;
#(
  parameter int CELL_WORDS  = 14,
  parameter int ADDR_WORD   = 6,
  parameter int DEPTH_CELLS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ip_vci,
  input  logic        in_soc,
  input  logic [31:0] in_data,
  output logic        in_tca,
  output logic        out_soc,
  output logic [31:0] out_data,
  input  logic        out_tca,
  output logic        req_push,
  output logic [31:0] req_addr,
  input  logic        req_full,
  input  logic        rsp_empty,
  input  logic [15:0] rsp_hop,
  output logic        rsp_pop
);
  localparam int DEPTH_WORDS = CELL_WORDS * DEPTH_CELLS;
  localparam int LVL_W       = $clog2(DEPTH_WORDS + 1);

  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_s_n, wr_en, rd_en;
  logic [LVL_W-1:0]       level;
  cw_t                    wr_word, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rs_q[SYNC_STAGES-1];

  atm_rw_ingress #(
    .CELL_WORDS(CELL_WORDS), .ADDR_WORD(ADDR_WORD),
    .DEPTH_WORDS(DEPTH_WORDS), .LVL_W(LVL_W)
  ) ing_i (
    .clk(clk), .rst_n(rst_s_n), .ip_vci(ip_vci), .in_soc(in_soc),
    .in_data(in_data), .in_tca(in_tca), .req_full(req_full),
    .req_push(req_push), .req_addr(req_addr), .level(level),
    .wr_en(wr_en), .wr_word(wr_word)
  );

  atm_rw_cellbuf #(.DEPTH(DEPTH_WORDS), .LVL_W(LVL_W)) buf_i (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_word(wr_word),
    .rd_en(rd_en), .rd_word(head), .level(level)
  );

  atm_rw_egress #(.CELL_WORDS(CELL_WORDS), .LVL_W(LVL_W)) egr_i (
    .clk(clk), .rst_n(rst_s_n), .level(level), .head(head), .rd_en(rd_en),
    .out_tca(out_tca), .rsp_empty(rsp_empty), .rsp_hop(rsp_hop),
    .rsp_pop(rsp_pop), .out_soc(out_soc), .out_data(out_data)
  );
endmodule

// File: rtl/atm_rw_checker.sv
module atm_rw_checker #(
  parameter int CELL_WORDS = 14
) (
  input logic clk,
  input logic rst_n,
  input logic in_tca,
  input logic out_soc,
  input logic out_tca,
  input logic req_push,
  input logic req_full,
  input logic rsp_empty,
  input logic rsp_pop
);
  localparam int GAP_W = $clog2(CELL_WORDS);
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap_q <= '0;
    else if (out_soc)    gap_q <= GAP_W'(CELL_WORDS - 1);
    else if (gap_q != 0) gap_q <= gap_q - 1'b1;
  end

  // R7
  tca_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |-> $past(out_tca));
  // R5
  pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pop |-> !rsp_empty);
  // R5
  pop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pop |=> !rsp_pop);
  // R2
  push_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_push |-> !req_full);
  // R8
  tca_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_tca |-> !req_full);
  // R6
  cell_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_soc |-> (gap_q == '0));
endmodule

bind atm_ip_vci_rewriter atm_rw_checker #(.CELL_WORDS(CELL_WORDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_tca(in_tca), .out_soc(out_soc),
  .out_tca(out_tca), .req_push(req_push), .req_full(req_full),
  .rsp_empty(rsp_empty), .rsp_pop(rsp_pop)
);

// File: tb/atm_ip_vci_rewriter_tb_top.sv
`timescale 1ns/1ps
module atm_ip_vci_rewriter_tb_top;
  localparam int CW = 14;
  localparam int NC = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ip_vci = 16'h003E;
  logic        in_soc = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_tca, out_soc, req_push, rsp_pop;
  logic [31:0] out_data, req_addr;
  logic        out_tca = 1'b1;
  logic        req_full = 1'b0;
  logic        rsp_empty = 1'b1;
  logic [15:0] rsp_hop = '0;

  atm_ip_vci_rewriter dut_i (
    .clk(clk), .rst_n(rst_n), .ip_vci(ip_vci), .in_soc(in_soc),
    .in_data(in_data), .in_tca(in_tca), .out_soc(out_soc),
    .out_data(out_data), .out_tca(out_tca), .req_push(req_push),
    .req_addr(req_addr), .req_full(req_full), .rsp_empty(rsp_empty),
    .rsp_hop(rsp_hop), .rsp_pop(rsp_pop)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // test controls
  int tca_mode = 1;       // 0 low, 1 high, 2 pattern
  bit hold_rsp = 1'b0, force_full = 1'b0;

  // source and expectation storage
  logic [31:0] src_w [NC*CW];
  logic [31:0] exp_w [NC*CW];
  int          exp_tag [NC];
  logic [31:0] exp_req [NC];
  int src_n = 0, src_sent = 0, drv_cell = 0, drv_k = 0, exp_req_n = 0;
  bit b_pkt = 1'b0;
  logic [15:0] b_hop = '0;

  // lookup queues
  logic [31:0] rq_addr [NC];
  int rq_time [NC];
  int rq_n = 0, rsp_head = 0, cyc = 0;

  // output capture
  logic [31:0] got_w [CW];
  int got_k = 0, out_cells = 0;
  bit rec_pop = 1'b0, rec_push = 1'b0;
  logic [31:0] rec_addr = '0;

  function automatic logic [15:0] hop_of(input logic [31:0] a);
    return a[31:16] ^ a[15:0] ^ 16'h0F0F;
  endfunction

  function automatic int lat_of(input int i);
    return 3 + ((i * 5) % 17);
  endfunction

  function automatic string tag_str(input int t);
    case (t)
      1:  return "R1";
      3:  return "R3";
      4:  return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  // Build one cell and its expected output from the requirements
  task automatic enqueue(input logic [15:0] vci, input bit last,
                         input logic [31:0] addr, input int seed);
    logic [31:0] hdr, w;
    bit ip, first;
    hdr = {12'(12'h1A0 + seed), vci, seed[3], seed[2], last, seed[0]};
    ip = (vci == ip_vci);
    first = ip && !b_pkt;
    if (first) begin
      b_hop = hop_of(addr);
      exp_req[exp_req_n] = addr;
      exp_req_n++;
    end
    if (ip) b_pkt = !last;
    for (int k = 0; k < CW; k++) begin
      if (k == 0)      w = hdr;
      else if (k == 6) w = addr;
      else             w = {8'(seed), 8'(k), 16'(seed * 31 + k)};
      src_w[src_n*CW + k] = w;
      exp_w[src_n*CW + k] = (k == 0 && ip) ? {hdr[31:20], b_hop, hdr[3:0]} : w;
    end
    if (!ip)        exp_tag[src_n] = (vci == 16'h003E || vci == 16'h0064) ? 10 : 1;
    else if (first) exp_tag[src_n] = 3;
    else            exp_tag[src_n] = 4;
    src_n++;
  endtask

  // Bench engine: all sampling and driving happens around the falling edge
  initial begin
    forever begin
      @(negedge clk);
      // capture outputs registered at the last rising edge
      if (got_k > 0) begin
        if (out_soc) chk(1'b0, "R6", "soc inside a cell", 32'(got_k), 32'd0);
        got_w[got_k] = out_data;
        got_k++;
      end else if (out_soc) begin
        got_w[0] = out_data;
        got_k = 1;
      end
      if (got_k == CW) begin
        bit ok;
        int bad;
        ok = 1'b1;
        bad = 0;
        if (out_cells >= src_n) ok = 1'b0;
        else
          for (int k = 0; k < CW; k++)
            if (ok && got_w[k] !== exp_w[out_cells*CW + k]) begin ok = 1'b0; bad = k; end
        // R1 R3 R4 R6 R10: each cell compared word by word in arrival order
        chk(ok, (out_cells < src_n) ? tag_str(exp_tag[out_cells]) : "R6",
            $sformatf("cell %0d word %0d", out_cells, bad), got_w[bad],
            (out_cells < src_n) ? exp_w[out_cells*CW + bad] : 32'hx);
        out_cells++;
        got_k = 0;
      end
      // effects of the last rising edge on the lookup queues
      if (rec_pop) rsp_head++;
      if (rec_push) begin
        // R2: pushed address matches the opening cell's word 6
        chk(rq_n < exp_req_n && rec_addr == exp_req[rq_n], "R2",
            $sformatf("request %0d", rq_n), rec_addr,
            (rq_n < exp_req_n) ? exp_req[rq_n] : 32'hx);
        if (rq_n < NC) begin
          rq_addr[rq_n] = rec_addr;
          rq_time[rq_n] = cyc;
          rq_n++;
        end
      end
      cyc++;
      req_full = force_full;
      out_tca = (tca_mode == 1) || (tca_mode == 2 && (cyc % 5) != 0);
      if (rsp_head < rq_n && !hold_rsp && cyc >= rq_time[rsp_head] + lat_of(rsp_head)) begin
        rsp_empty = 1'b0;
        rsp_hop = hop_of(rq_addr[rsp_head]);
      end else begin
        rsp_empty = 1'b1;
        rsp_hop = 16'h0;
      end
      #1;
      if (drv_k > 0) begin
        in_soc = 1'b0;
        in_data = src_w[drv_cell*CW + drv_k];
        drv_k = (drv_k == CW - 1) ? 0 : drv_k + 1;
      end else if (src_sent < src_n && in_tca) begin
        in_soc = 1'b1;
        drv_cell = src_sent;
        in_data = src_w[drv_cell*CW];
        src_sent++;
        drv_k = 1;
      end else begin
        in_soc = 1'b0;
        in_data = '0;
      end
      #1;
      rec_pop = rsp_pop;
      rec_push = req_push;
      rec_addr = req_addr;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((out_cells < src_n || got_k != 0) && t < 6000) begin
      wait_cycles(1);
      t++;
    end
    chk(t < 6000, "R6", "drain", 32'(out_cells), 32'(src_n));
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait_cycles(5);
    rst_n = 1'b1;
    wait_cycles(6);
    // R9: idle state after reset
    chk(out_soc == 1'b0, "R9", "out_soc", 32'(out_soc), 32'd0);
    chk(out_data == '0, "R9", "out_data", out_data, 32'd0);
    chk(req_push == 1'b0, "R9", "req_push", 32'(req_push), 32'd0);
    chk(rsp_pop == 1'b0, "R9", "rsp_pop", 32'(rsp_pop), 32'd0);
    chk(in_tca == 1'b1, "R9", "in_tca", 32'(in_tca), 32'd1);

    // R5: IP cell waits for a result
    hold_rsp = 1'b1;
    enqueue(16'h003E, 1'b1, 32'h0ABAC000, 1);
    wait_cycles(60);
    chk(out_cells == 0, "R5", "cell left before result", 32'(out_cells), 32'd0);
    chk(rsp_head == 0, "R5", "pop before result", 32'(rsp_head), 32'd0);
    chk(rq_n == 1, "R2", "request issued", 32'(rq_n), 32'd1);
    hold_rsp = 1'b0;
    drain();

    // R7: downstream flow control holds a cell
    tca_mode = 0;
    enqueue(16'h0123, 1'b0, 32'h11112222, 2);
    wait_cycles(50);
    chk(out_cells == 1, "R7", "cell sent while tca low", 32'(out_cells), 32'd1);
    tca_mode = 1;
    drain();

    // R8: buffer room gates the input
    tca_mode = 0;
    for (int i = 0; i < 5; i++) enqueue(16'h0200 + 16'(i), 1'b1, 32'h0, 3 + i);
    wait_cycles(120);
    chk(in_tca == 1'b0, "R8", "in_tca with full buffer", 32'(in_tca), 32'd0);
    chk(src_sent == src_n - 1, "R8", "cells accepted", 32'(src_sent), 32'(src_n - 1));
    tca_mode = 1;
    drain();
    // R8: request queue full gates the input
    force_full = 1'b1;
    wait_cycles(3);
    chk(in_tca == 1'b0, "R8", "in_tca with req_full", 32'(in_tca), 32'd0);
    enqueue(16'h0300, 1'b1, 32'h0, 9);
    wait_cycles(30);
    chk(src_sent == src_n - 1, "R8", "cell accepted under req_full", 32'(src_sent), 32'(src_n - 1));
    force_full = 1'b0;
    drain();

    // Sweep: both IP circuits, packet lengths 1..3, three interleave patterns
    tca_mode = 2;
    for (int vs = 0; vs < 2; vs++) begin
      logic [15:0] other;
      ip_vci = vs ? 16'h0064 : 16'h003E;  // R10: reconfigured while idle
      other  = vs ? 16'h003E : 16'h0064;
      for (int len = 1; len <= 3; len++)
        for (int mix = 0; mix < 3; mix++) begin
          logic [31:0] a;
          a = 32'h0A000000 + 32'(vs << 20) + 32'(len << 12) + 32'(mix * 32'h111);
          for (int c = 0; c < len; c++) begin
            enqueue(ip_vci, c == len - 1, a, 16 + vs*64 + len*12 + mix*4 + c);
            if (mix == 1) enqueue(ip_vci ^ 16'h0100, c[0], 32'hCAFE0000 + 32'(c), 40 + c);
            if (mix == 2) enqueue(other, 1'b0, 32'hBEEF0000 + 32'(c), 50 + c);
          end
        end
      drain();
    end

    // R2 R5 R6: totals
    chk(rq_n == exp_req_n, "R2", "request count", 32'(rq_n), 32'(exp_req_n));
    chk(rsp_head == exp_req_n, "R5", "pop count", 32'(rsp_head), 32'(exp_req_n));
    chk(out_cells == src_n, "R6", "cells out", 32'(out_cells), 32'(src_n));
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got %0d exp %0d", out_cells, src_n);
      finish_run();
    end
  end
endmodule